// File: doc/BRIEF.md
# I2C Serial-EEPROM Write Target

This block sits on a two-wire serial bus as a target and behaves like a serial EEPROM on its write path. SCL and SDA are brought into the system clock domain through two-flop synchronizers. The block then detects START and STOP and shifts in bytes MSB first. It compares the control byte against a 7-bit device address made of the fixed prefix `1010` and three strap pins. After the control byte it takes a two-byte memory pointer and then any number of data bytes. It acknowledges each accepted byte by enabling an open-drain pull-down on SDA during the ninth clock.

Data bytes are not written to the array when they arrive. They go into a one-page buffer, and the sequential pointer wraps inside the current page. A STOP that follows at least one data byte starts a self-timed write cycle. During that cycle the buffered bytes are copied into the byte array and `busy_o` stays high for a fixed number of system clocks. While the cycle runs, every control byte is left unacknowledged, so no new transfer can begin. A side port gives combinational read access to the array for neighbouring logic.

The protocol engine has these states. `ST_IDLE` waits for a START. `ST_CTRL`, `ST_ADDR_HI`, `ST_ADDR_LO` and `ST_DATA` each shift in one byte. `ST_ACK` drives the acknowledge. `ST_SKIP` holds SDA released until the next START or STOP.

Transitions:
- A START moves any state to `ST_CTRL` and clears the bit count.
- A STOP moves any state to `ST_IDLE`.
- In a receiving state, the SCL fall after the eighth bit moves to `ST_ACK` if the byte is accepted, otherwise to `ST_SKIP`.
- `ST_ACK` moves on the next SCL fall: `ST_CTRL` goes to `ST_ADDR_HI`, `ST_ADDR_HI` to `ST_ADDR_LO`, and `ST_ADDR_LO` and `ST_DATA` both go to `ST_DATA`.

Top module: `eeprom_wr_target`

## Requirements
- R1: After reset, `busy_o` and `sda_pd_o` are low and every array byte reads 0 on the peek port.
- R2: A control byte equal to {4'b1010, strap_i[2:0], 1'b0} is acknowledged; one with different address bits is not acknowledged, and the rest of that transfer writes nothing and starts no write cycle.
- R3: A control byte whose LSB (R/W bit) is 1 is not acknowledged.
- R4: The two bytes after an accepted control byte form the memory pointer, high byte first, and each is acknowledged. Bits are taken MSB first on SCL rising. The array index is the 16-bit pointer modulo MEM_BYTES.
- R5: Data bytes are acknowledged but leave the array unchanged until STOP.
- R6: A STOP after one or more buffered data bytes raises `busy_o` for exactly TWC_CYCLES system clocks. Once it falls, the array holds the buffered bytes.
- R7: While `busy_o` is high, a matching control byte is not acknowledged, and the bytes that follow it are not written.
- R8: Successive data bytes go to successive addresses, and the page offset (pointer modulo PAGE_BYTES) wraps to 0 within the same page. When the same location is written twice in one transfer, the later byte is kept.
- R9: A START in the middle of a byte restarts bit counting, so a complete transfer after it works normally.
- R10: A repeated START drops the data bytes buffered before it; only bytes received after the last START are written at STOP.
- R11: A STOP with no data byte after the pointer starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| strap_i | input | 3 | Low three bits of the device address |
| sda_pd_o | output | 1 | Pull-down enable for SDA (acknowledge) |
| busy_o | output | 1 | Self-timed write cycle in progress |
| peek_addr_i | input | clog2(MEM_BYTES) | Array read address |
| peek_data_o | output | 8 | Array byte at peek_addr_i |

## Verification
The bench builds the block with MEM_BYTES = 256, PAGE_BYTES = 8 and TWC_CYCLES = 400. The small page lets a transfer of up to twelve bytes wrap and overwrite its own page. The short write cycle lets a second transfer land inside the busy window and another start right after it. With 256 bytes, random 16-bit pointers exercise the modulo mapping, and the whole array is compared against a bench model after every transfer.

// File: rtl/eewt_pkg.sv
package eewt_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA,
        ST_ACK,
        ST_SKIP
    } proto_state_e;

endpackage

// File: rtl/eewt_line_sync.sv
module eewt_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);
    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_s, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
            sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
        end else begin
            scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
            sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
        end
    end

    assign scl_rise_o = scl_s & ~scl_p;
    assign scl_fall_o = ~scl_s & scl_p;
    assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
    assign sda_o      = sda_s;

endmodule

// File: rtl/eewt_proto.sv
module eewt_proto
    import eewt_pkg::*;
#(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_rise_i,
    input  logic                     scl_fall_i,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic                     sda_i,
    input  logic [2:0]               strap_i,
    input  logic                     busy_i,
    output logic                     sda_pd_o,
    output logic                     buf_we_o,
    output logic [$clog2(PAGE_BYTES)-1:0] buf_idx_o,
    output logic [7:0]               buf_data_o,
    output logic                     clr_o,
    output logic                     commit_req_o,
    output logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] commit_page_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int HW = (AW > 8) ? AW - 8 : 1;

    proto_state_e state_q, state_d, nxt_q;
    logic [2:0]    bitcnt_q;
    logic [6:0]    shreg_q;
    logic          byte_rdy_q;
    logic          ack_q;
    logic          have_data_q;
    logic [HW-1:0] ahi_q;
    logic [AW-1:0] ptr_q;
    logic [7:0]    rx;
    logic [AW-1:0] addr_join;
    logic          receiving;

    assign rx        = {shreg_q, sda_i};
    assign receiving = (state_q == ST_CTRL) || (state_q == ST_ADDR_HI) ||
                       (state_q == ST_ADDR_LO) || (state_q == ST_DATA);

    generate
        if (AW > 8) begin : g_wide
            assign addr_join = {ahi_q, rx};
        end else begin : g_narrow
            assign addr_join = rx[AW-1:0];
        end
    endgenerate

    assign commit_page_o = ptr_q[AW-1:PW];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_CTRL;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: state_d = state_q;
                ST_CTRL, ST_ADDR_HI, ST_ADDR_LO, ST_DATA:
                    if (scl_fall_i && byte_rdy_q)
                        state_d = ack_q ? ST_ACK : ST_SKIP;
                ST_ACK:
                    if (scl_fall_i) state_d = nxt_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q     <= '0;
            shreg_q      <= '0;
            byte_rdy_q   <= 1'b0;
            ack_q        <= 1'b0;
            nxt_q        <= ST_IDLE;
            have_data_q  <= 1'b0;
            ahi_q        <= '0;
            ptr_q        <= '0;
            sda_pd_o     <= 1'b0;
            buf_we_o     <= 1'b0;
            buf_idx_o    <= '0;
            buf_data_o   <= '0;
            clr_o        <= 1'b0;
            commit_req_o <= 1'b0;
        end else begin
            buf_we_o     <= 1'b0;
            clr_o        <= 1'b0;
            commit_req_o <= 1'b0;
            if (start_i) begin
                bitcnt_q    <= '0;
                byte_rdy_q  <= 1'b0;
                sda_pd_o    <= 1'b0;
                have_data_q <= 1'b0;
                clr_o       <= 1'b1;
            end else if (stop_i) begin
                commit_req_o <= have_data_q && !busy_i;
                have_data_q  <= 1'b0;
                byte_rdy_q   <= 1'b0;
                sda_pd_o     <= 1'b0;
            end else begin
                if (receiving && scl_rise_i && !byte_rdy_q) begin
                    shreg_q <= rx[6:0];
                    if (bitcnt_q == 3'd7) begin
                        bitcnt_q   <= '0;
                        byte_rdy_q <= 1'b1;
                        unique case (state_q)
                            ST_CTRL: begin
                                ack_q <= (rx[7:1] == {DEV_PREFIX, strap_i}) &&
                                         !rx[0] && !busy_i;
                                nxt_q <= ST_ADDR_HI;
                            end
                            ST_ADDR_HI: begin
                                ahi_q <= rx[HW-1:0];
                                ack_q <= 1'b1;
                                nxt_q <= ST_ADDR_LO;
                            end
                            ST_ADDR_LO: begin
                                ptr_q <= addr_join;
                                ack_q <= 1'b1;
                                nxt_q <= ST_DATA;
                            end
                            ST_DATA: begin
                                buf_we_o    <= 1'b1;
                                buf_idx_o   <= ptr_q[PW-1:0];
                                buf_data_o  <= rx;
                                have_data_q <= 1'b1;
                                ptr_q       <= {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
                                ack_q       <= 1'b1;
                                nxt_q       <= ST_DATA;
                            end
                            default: ack_q <= 1'b0;
                        endcase
                    end else begin
                        bitcnt_q <= bitcnt_q + 3'd1;
                    end
                end
                if (receiving && scl_fall_i && byte_rdy_q) begin
                    byte_rdy_q <= 1'b0;
                    sda_pd_o   <= ack_q;
                end
                if (state_q == ST_ACK && scl_fall_i) begin
                    sda_pd_o <= 1'b0;
                end
            end
        end
    end

    // R4: the pull-down is only ever enabled in the acknowledge slot
    p_pd_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pd_o |-> state_q == ST_ACK);

    // R9: START always restarts the control byte from bit zero
    p_start_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_CTRL) && (bitcnt_q == 3'd0));

    // R6: STOP returns the engine to idle
    p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> state_q == ST_IDLE);

    // R7: no buffer write while the write cycle runs
    p_no_fill_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> !busy_i);

    // R7: no commit request while a write cycle runs
    p_no_commit_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req_o |-> !busy_i);

endmodule

// File: rtl/eewt_commit.sv
module eewt_commit #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 64,
    parameter int TWC_CYCLES = 500000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     buf_we_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] buf_idx_i,
    input  logic [7:0]               buf_data_i,
    input  logic                     commit_req_i,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] commit_page_i,
    input  logic [$clog2(MEM_BYTES)-1:0] peek_addr_i,
    output logic [7:0]               peek_data_o,
    output logic                     busy_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int BW = AW - PW;
    localparam int TW = $clog2(TWC_CYCLES + 1);

    logic [7:0]            mem_q [MEM_BYTES];
    logic [7:0]            buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;
    logic [TW-1:0]         timer_q;
    logic                  copying_q;
    logic [PW-1:0]         walk_q;
    logic [BW-1:0]         base_q;
    logic                  do_copy;

    assign do_copy     = busy_o && copying_q && vld_q[walk_q];
    assign peek_data_o = mem_q[peek_addr_i];

    always_ff @(posedge clk) begin
        if (buf_we_i) buf_q[buf_idx_i] <= buf_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
        end else if (do_copy) begin
            mem_q[{base_q, walk_q}] <= buf_q[walk_q];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q     <= '0;
            busy_o    <= 1'b0;
            timer_q   <= '0;
            copying_q <= 1'b0;
            walk_q    <= '0;
            base_q    <= '0;
        end else begin
            if (clr_i && !busy_o) vld_q <= '0;
            if (buf_we_i) vld_q[buf_idx_i] <= 1'b1;
            if (commit_req_i && !busy_o) begin
                busy_o    <= 1'b1;
                timer_q   <= TW'(TWC_CYCLES - 1);
                copying_q <= 1'b1;
                walk_q    <= '0;
                base_q    <= commit_page_i;
            end else if (busy_o) begin
                if (timer_q == '0) busy_o <= 1'b0;
                else               timer_q <= timer_q - 1'b1;
                if (copying_q) begin
                    walk_q <= walk_q + 1'b1;
                    if (walk_q == PW'(PAGE_BYTES - 1)) begin
                        copying_q <= 1'b0;
                        vld_q     <= '0;
                    end
                end
            end
        end
    end

    // R6: a write cycle only begins in response to a commit request
    p_busy_from_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(commit_req_i));

    // R6: the buffer copy never outlives the busy window
    p_copy_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !copying_q);

endmodule

// File: rtl/eeprom_wr_target.sv
module eeprom_wr_target #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 64,
    parameter int TWC_CYCLES = 500000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    input  logic [2:0]                   strap_i,
    output logic                         sda_pd_o,
    output logic                         busy_o,
    input  logic [$clog2(MEM_BYTES)-1:0] peek_addr_i,
    output logic [7:0]                   peek_data_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int BW = AW - PW;

    logic          scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic          buf_we, clr, commit_req;
    logic [PW-1:0] buf_idx;
    logic [7:0]    buf_data;
    logic [BW-1:0] commit_page;

    eewt_line_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .sda_o      (sda_s)
    );

    eewt_proto #(
        .MEM_BYTES  (MEM_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_proto (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_rise_i    (scl_rise),
        .scl_fall_i    (scl_fall),
        .start_i       (start_det),
        .stop_i        (stop_det),
        .sda_i         (sda_s),
        .strap_i       (strap_i),
        .busy_i        (busy_o),
        .sda_pd_o      (sda_pd_o),
        .buf_we_o      (buf_we),
        .buf_idx_o     (buf_idx),
        .buf_data_o    (buf_data),
        .clr_o         (clr),
        .commit_req_o  (commit_req),
        .commit_page_o (commit_page)
    );

    eewt_commit #(
        .MEM_BYTES  (MEM_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .TWC_CYCLES (TWC_CYCLES)
    ) u_commit (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (clr),
        .buf_we_i      (buf_we),
        .buf_idx_i     (buf_idx),
        .buf_data_i    (buf_data),
        .commit_req_i  (commit_req),
        .commit_page_i (commit_page),
        .peek_addr_i   (peek_addr_i),
        .peek_data_o   (peek_data_o),
        .busy_o        (busy_o)
    );

    // R1: outputs come out of reset quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !busy_o && !sda_pd_o);

endmodule

// File: tb/eeprom_wr_target_bench.sv
module eeprom_wr_target_bench;
    localparam int MEM  = 256;
    localparam int PAGE = 8;
    localparam int TWC  = 400;
    localparam int AW   = $clog2(MEM);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_drv = 1'b1;
    logic [2:0]    strap = 3'b000;
    logic          sda_pd, busy;
    logic [AW-1:0] peek_addr = '0;
    logic [7:0]    peek_data;
    wire           sda_line = sda_drv & ~sda_pd;

    int n_checks = 0;
    int n_fail   = 0;
    int run_len  = 0;
    int last_len = 0;
    int cyc      = 0;

    logic [7:0] ref_mem [MEM];
    logic [7:0] dq [16];

    always #5 clk = ~clk;

    eeprom_wr_target #(
        .MEM_BYTES  (MEM),
        .PAGE_BYTES (PAGE),
        .TWC_CYCLES (TWC)
    ) u_eeprom_wr_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .strap_i     (strap),
        .sda_pd_o    (sda_pd),
        .busy_o      (busy),
        .peek_addr_i (peek_addr),
        .peek_data_o (peek_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (busy) run_len <= run_len + 1;
        else if (run_len != 0) begin
            last_len <= run_len;
            run_len  <= 0;
        end
    end

    initial begin
        wait (cyc > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    function automatic logic [7:0] ctrl_byte(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic v);
        tick(3); sda_drv = v; tick(5); scl = 1'b1; tick(8); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        tick(3); sda_drv = 1'b1; tick(5); scl = 1'b1; tick(4);
        ack = !sda_line;
        tick(4); scl = 1'b0;
    endtask

    task automatic do_start();
        tick(3); sda_drv = 1'b1; tick(5); scl = 1'b1; tick(8);
        sda_drv = 1'b0; tick(8); scl = 1'b0;
    endtask

    task automatic do_stop();
        tick(3); sda_drv = 1'b0; tick(5); scl = 1'b1; tick(8);
        sda_drv = 1'b1; tick(8);
    endtask

    task automatic model_write(input logic [15:0] a, input int n);
        int base = (int'(a) % MEM) & ~(PAGE - 1);
        int off  = int'(a) % PAGE;
        for (int i = 0; i < n; i++) ref_mem[base + ((off + i) % PAGE)] = dq[i];
    endtask

    task automatic send_body(input logic [15:0] a, input int n, output bit all_ack);
        bit ack;
        all_ack = 1'b1;
        send_byte(ctrl_byte(strap, 1'b0), ack); all_ack &= ack;
        send_byte(a[15:8], ack); all_ack &= ack;
        send_byte(a[7:0], ack);  all_ack &= ack;
        for (int i = 0; i < n; i++) begin
            send_byte(dq[i], ack); all_ack &= ack;
        end
    endtask

    task automatic wait_idle();
        tick(10);
        while (busy) tick(1);
        tick(3);
    endtask

    task automatic check_mem(input string req);
        int bad = -1;
        for (int a = 0; a < MEM; a++) begin
            peek_addr = AW'(a);
            #1;
            if (bad < 0 && peek_data !== ref_mem[a]) bad = a;
        end
        if (bad < 0) chk(1'b1, req, 0, 0);
        else begin
            peek_addr = AW'(bad);
            #1;
            chk(1'b0, req, int'(peek_data), int'(ref_mem[bad]));
        end
    endtask

    initial begin
        bit ack, all;
        logic [15:0] ra;
        int rn;
        void'($urandom(32'd2718));
        for (int i = 0; i < MEM; i++) ref_mem[i] = 8'h00;
        tick(5); rst_n = 1'b1; tick(5);

        // R1: reset state
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(sda_pd == 1'b0, "R1 pull-down after reset", int'(sda_pd), 0);
        check_mem("R1 array cleared");

        // R2 R4 R5: single byte 0x55 to 0x00A2, straps low
        dq[0] = 8'h55;
        do_start();
        send_body(16'h00A2, 1, all);
        chk(all, "R4 R2 control, pointer and data acknowledged", int'(all), 1);
        peek_addr = AW'(8'hA2); #1;
        chk(peek_data == 8'h00 && !busy, "R5 array unchanged before STOP", int'(peek_data), 0);
        do_stop();
        model_write(16'h00A2, 1);
        tick(5);
        chk(busy == 1'b1, "R6 busy after STOP", int'(busy), 1);

        // R7: transfer during busy window is refused and ignored
        dq[0] = 8'hEE;
        do_start();
        send_byte(ctrl_byte(strap, 1'b0), ack);
        chk(!ack, "R7 control byte NACK while busy", int'(ack), 0);
        send_byte(8'h00, ack); send_byte(8'h10, ack); send_byte(8'hEE, ack);
        do_stop();
        wait_idle();
        chk(last_len == TWC, "R6 busy window length", last_len, TWC);
        check_mem("R6 R7 array after commit");
        tick(20);
        chk(!busy, "R7 ignored transfer starts no cycle", int'(busy), 0);

        // R2: straps change the address
        strap = 3'b101;
        do_start();
        send_byte(ctrl_byte(3'b000, 1'b0), ack);
        chk(!ack, "R2 wrong address NACK", int'(ack), 0);
        send_byte(8'h00, ack); send_byte(8'h20, ack); send_byte(8'h77, ack);
        do_stop(); tick(20);
        chk(!busy, "R2 wrong address starts no cycle", int'(busy), 0);
        dq[0] = 8'hA5; dq[1] = 8'h5A;
        do_start(); send_body(16'h1234, 2, all); do_stop();
        model_write(16'h1234, 2);
        chk(all, "R2 R4 strapped address acknowledged", int'(all), 1);
        wait_idle();
        check_mem("R2 R4 strapped write, pointer modulo size");

        // R3: read bit refused
        do_start();
        send_byte(ctrl_byte(strap, 1'b1), ack);
        chk(!ack, "R3 read control byte NACK", int'(ack), 0);
        do_stop(); tick(20);

        // R8: wrap inside page (pointer 6, page of 8)
        dq[0] = 8'h11; dq[1] = 8'h22; dq[2] = 8'h33; dq[3] = 8'h44;
        do_start(); send_body(16'h0006, 4, all); do_stop();
        model_write(16'h0006, 4);
        wait_idle();
        peek_addr = AW'(0); #1;
        chk(peek_data == 8'h33, "R8 wrap to page start", int'(peek_data), 8'h33);
        peek_addr = AW'(8); #1;
        chk(peek_data == 8'h00, "R8 next page untouched", int'(peek_data), 0);
        check_mem("R8 page wrap array");

        // R11: pointer only, no data
        do_start();
        send_byte(ctrl_byte(strap, 1'b0), ack);
        send_byte(8'h00, ack); send_byte(8'h40, ack);
        do_stop(); tick(20);
        chk(!busy, "R11 no data, no write cycle", int'(busy), 0);

        // R9: START inside a byte
        do_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        dq[0] = 8'h9C;
        do_start(); send_body(16'h0050, 1, all); do_stop();
        model_write(16'h0050, 1);
        chk(all, "R9 transfer after mid-byte START acknowledged", int'(all), 1);
        wait_idle();
        check_mem("R9 array after mid-byte START");

        // R10: repeated START drops earlier bytes
        dq[0] = 8'hC1; dq[1] = 8'hC2;
        do_start(); send_body(16'h0060, 2, all);
        dq[0] = 8'hD7;
        do_start(); send_body(16'h0070, 1, all); do_stop();
        model_write(16'h0070, 1);
        wait_idle();
        check_mem("R10 only last segment written");

        // random transfers, including wrap and overwrite
        for (int t = 0; t < 20; t++) begin
            ra = 16'($urandom);
            rn = 1 + int'($urandom % 12);
            for (int i = 0; i < rn; i++) dq[i] = 8'($urandom);
            do_start(); send_body(ra, rn, all); do_stop();
            model_write(ra, rn);
            chk(all, "R4 R8 random transfer acknowledged", int'(all), 1);
            wait_idle();
            chk(last_len == TWC, "R6 random busy window", last_len, TWC);
            check_mem("R6 R8 random array contents");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule